// File: doc/BRIEF.md
# Four-channel double-buffered DAC register bank

This block is the register front end for four 12-bit digital-to-analog channels. A host on a 16-bit register bus, with separate write and read strobes and a word address, loads a staging code for each channel and a staging word of per-channel range bits (bipolar select and gain select). Neither reaches the analog stage until the host commits it. A read of the data-commit address moves all four staged codes to the live outputs on the same clock edge. A read of the range-commit address does the same for the range bits.

A mode register holds two bits. The enable bit parks all four live codes at midscale while it is clear; the staging registers still take writes during that time. The buffered bit chooses between committed updates and direct updates. With buffering off, a write to a channel's code, or to the range word, reaches the live outputs on the next edge without a commit.

The word address is the byte offset divided by two. The mode register and the data commit share word 1. The range word and the range commit share word 9. The channel codes sit at words 10 to 13.

Top module: `quad_dac_regs`

## Requirements
- R1: After reset the mode register, the staging and live codes and the range bits are all zero. All four codes read midscale 0x800, and every bipolar and gain output is 0.
- R2: A write to word address 10+i (byte offset 0x14+2i) loads channel i's staging code (i=0..3) with bits 11:0 of the write data. Bits 15:12 are dropped.
- R3: In the range word, channel i's bipolar select is bit 7-i and its gain select is bit 11-i. Bits 15:12, 3:0 and the unused positions have no effect.
- R4: With buffered mode on, code writes leave the live codes unchanged. A read of word 1 (byte 0x02) copies all four staged codes to the live codes together, visible one clock edge after the read strobe.
- R5: With buffered mode on, a range-word write leaves the bipolar and gain outputs unchanged. A read of word 9 (byte 0x12) copies the staged range word to them one clock edge after the strobe.
- R6: With buffered mode off, a code write to a channel updates that channel's live code on the next clock edge.
- R7: With buffered mode off, a range-word write updates the bipolar and gain outputs on the next clock edge.
- R8: While the enable bit is clear, all four codes read 0x800, and code writes and commits still update the stored values. Setting the enable bit exposes those stored values.
- R9: A write to word 1 sets the enable bit from data bit 1 and the buffered bit from data bit 0.
- R10: Without a commit read or a direct write, the live codes and range bits hold their values.
- R11: Reads of addresses other than words 1 and 9, and writes to unmapped words, change no output and no staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 5 | Word address (byte offset / 2) |
| bus_wdata | input | 16 | Write data |
| dac_code_o | output | 48 | Live codes, channel i at bits 12i+11:12i |
| bipolar_o | output | 4 | Live bipolar select, bit i for channel i |
| gain_o | output | 4 | Live gain select, bit i for channel i |

## Verification
Assertions check the following on every clock:
- A data commit copies each channel's staged code into its live register.
- A direct write in unbuffered mode lands on the next edge.
- Live codes and range bits hold when nothing commits or writes them.
- The range commit and the mode-register writes take effect.

The bench's scenarios cover what the assertions do not: the address map, and the dropping of high data bits and stray range bits. They also cover midscale parking while disabled and the later exposure of values staged in that time. Last, they show that bus traffic to unmapped words leaves the staged state intact, which is visible only after a later commit.

// File: rtl/dacr_pkg.sv
package dacr_pkg;
    // Word addresses derived from byte offsets on a 16-bit bus
    localparam int MODE_BYTE   = 'h02;
    localparam int RANGE_BYTE  = 'h12;
    localparam int DATA0_BYTE  = 'h14;
    localparam int W_MODE      = MODE_BYTE >> 1;
    localparam int W_RANGE     = RANGE_BYTE >> 1;
    localparam int W_DATA0     = DATA0_BYTE >> 1;

    // Channel 0 control-bit positions; channel i sits i positions lower
    localparam int BIP_TOP     = 7;
    localparam int GAIN_TOP    = 11;

    // Mode-register bit positions
    localparam int MODE_EN_BIT  = 1;
    localparam int MODE_BUF_BIT = 0;

    typedef struct packed {
        logic en;
        logic bufm;
    } mode_t;
endpackage

// File: rtl/dacr_decode.sv
module dacr_decode
    import dacr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 5
) (
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              mode_wr_o,
    output logic              range_wr_o,
    output logic              range_commit_o,
    output logic              data_commit_o,
    output logic [NCH-1:0]    data_wr_o
);
    always_comb begin
        mode_wr_o      = wr_i && (addr_i == ADDR_W'(W_MODE));
        range_wr_o     = wr_i && (addr_i == ADDR_W'(W_RANGE));
        range_commit_o = rd_i && (addr_i == ADDR_W'(W_RANGE));
        data_commit_o  = rd_i && (addr_i == ADDR_W'(W_MODE));
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dsel
        assign data_wr_o[g] = wr_i && (addr_i == ADDR_W'(W_DATA0 + g));
    end
endmodule

// File: rtl/dacr_mode.sv
module dacr_mode
    import dacr_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic             en_o,
    output logic             bufm_o
);
    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr_i) begin
            mode_d.en   = wdata_i[MODE_EN_BIT];
            mode_d.bufm = wdata_i[MODE_BUF_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign en_o   = mode_q.en;
    assign bufm_o = mode_q.bufm;

    p_mode_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(wdata_i[MODE_EN_BIT])) &&
                 (bufm_o == $past(wdata_i[MODE_BUF_BIT])));
endmodule

// File: rtl/dacr_range.sv
module dacr_range
    import dacr_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             commit_i,
    input  logic             bufm_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [NCH-1:0]   bipolar_o,
    output logic [NCH-1:0]   gain_o
);
    typedef struct packed {
        logic [NCH-1:0] bip;
        logic [NCH-1:0] gain;
    } rsel_t;

    typedef struct packed {
        rsel_t stage;
        rsel_t live;
    } rstate_t;

    rstate_t r_d, r_q;
    rsel_t   wsel;
    logic    direct;

    // Per-channel bits at positions shifted right by the channel index
    for (genvar g = 0; g < NCH; g++) begin : g_ext
        assign wsel.bip[g]  = wdata_i[BIP_TOP - g];
        assign wsel.gain[g] = wdata_i[GAIN_TOP - g];
    end

    assign direct = wr_i && !bufm_i;

    always_comb begin
        r_d = r_q;
        if (commit_i) r_d.live  = r_q.stage;
        if (wr_i)     r_d.stage = wsel;
        if (direct)   r_d.live  = wsel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bipolar_o = r_q.live.bip;
    assign gain_o    = r_q.live.gain;

    p_range_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !direct) |=> (r_q.live == $past(r_q.stage)));

    p_range_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        direct |=> (bipolar_o == $past(wsel.bip)) && (gain_o == $past(wsel.gain)));

    p_range_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && !direct) |=> $stable(bipolar_o) && $stable(gain_o));
endmodule

// File: rtl/dacr_chan.sv
module dacr_chan #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          commit_i,
    input  logic          bufm_i,
    input  logic          en_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] code_o
);
    localparam logic [DW-1:0] MIDSCALE = DW'(1) << (DW - 1);

    typedef struct packed {
        logic [DW-1:0] stage;
        logic [DW-1:0] live;
    } cstate_t;

    cstate_t c_d, c_q;
    logic    direct;

    assign direct = wr_i && !bufm_i;

    always_comb begin
        c_d = c_q;
        if (commit_i) c_d.live  = c_q.stage;
        if (wr_i)     c_d.stage = wdata_i;
        if (direct)   c_d.live  = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign code_o = en_i ? c_q.live : MIDSCALE;

    p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !direct) |=> (c_q.live == $past(c_q.stage)));

    p_direct_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        direct |=> (c_q.live == $past(wdata_i)));

    p_stage_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (c_q.stage == $past(wdata_i)));

    p_live_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && !direct) |=> $stable(c_q.live));
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
    import dacr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 12,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [NCH*DW-1:0] dac_code_o,
    output logic [NCH-1:0]    bipolar_o,
    output logic [NCH-1:0]    gain_o
);
    logic           mode_wr, range_wr, range_commit, data_commit;
    logic [NCH-1:0] data_wr;
    logic           en, bufm;

    dacr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .wr_i           (bus_wr),
        .rd_i           (bus_rd),
        .addr_i         (bus_addr),
        .mode_wr_o      (mode_wr),
        .range_wr_o     (range_wr),
        .range_commit_o (range_commit),
        .data_commit_o  (data_commit),
        .data_wr_o      (data_wr)
    );

    dacr_mode #(.BUS_W(BUS_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mode_wr),
        .wdata_i (bus_wdata),
        .en_o    (en),
        .bufm_o  (bufm)
    );

    dacr_range #(.NCH(NCH), .BUS_W(BUS_W)) u_range (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (range_wr),
        .commit_i  (range_commit),
        .bufm_i    (bufm),
        .wdata_i   (bus_wdata),
        .bipolar_o (bipolar_o),
        .gain_o    (gain_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dacr_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (data_wr[g]),
            .commit_i (data_commit),
            .bufm_i   (bufm),
            .en_i     (en),
            .wdata_i  (bus_wdata[DW-1:0]),
            .code_o   (dac_code_o[g*DW +: DW])
        );
    end

    // At most one channel-select is ever active per cycle
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_wr));
endmodule

// File: tb/tb_quad_dac_regs.sv
`timescale 1ns/1ps
module tb_quad_dac_regs;
    localparam int NCH = 4;
    localparam int DW  = 12;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              bus_wr = 0, bus_rd = 0;
    logic [4:0]        bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [NCH*DW-1:0] dac_code_o;
    logic [NCH-1:0]    bipolar_o, gain_o;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    quad_dac_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .dac_code_o(dac_code_o), .bipolar_o(bipolar_o), .gain_o(gain_o)
    );

    // Behavioural reference model
    int m_stage[4];
    int m_live[4];
    int m_rstage, m_rlive;
    bit m_en, m_buf;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_stage[i]) begin m_stage[i] = 0; m_live[i] = 0; end
            m_rstage = 0; m_rlive = 0; m_en = 0; m_buf = 0;
        end else begin
            if (bus_rd && bus_addr == 1)
                foreach (m_live[i]) m_live[i] = m_stage[i];
            if (bus_rd && bus_addr == 9)
                m_rlive = m_rstage;
            if (bus_wr) begin
                if (bus_addr == 9) begin
                    m_rstage = bus_wdata & 16'h0FF0;
                    if (!m_buf) m_rlive = m_rstage;
                end else if (bus_addr >= 10 && bus_addr <= 13) begin
                    m_stage[bus_addr-10] = bus_wdata & 16'h0FFF;
                    if (!m_buf) m_live[bus_addr-10] = m_stage[bus_addr-10];
                end else if (bus_addr == 1) begin
                    m_en  = bus_wdata[1];
                    m_buf = bus_wdata[0];
                end
            end
        end
    end

    function automatic int exp_code(int i);
        return m_en ? m_live[i] : 'h800;
    endfunction

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NCH; i++) begin
                int act_c, act_b, act_g, e_b, e_g;
                act_c = dac_code_o[i*DW +: DW];
                act_b = bipolar_o[i];
                act_g = gain_o[i];
                e_b = (m_rlive >> (7 - i)) & 1;
                e_g = (m_rlive >> (11 - i)) & 1;
                n_checks++;
                if (act_c != exp_code(i) || act_b != e_b || act_g != e_g) begin
                    n_fail++;
                    $display("FAIL %s ch%0d: code=%h bip=%0d gain=%0d expected code=%h bip=%0d gain=%0d",
                             cur_req, i, act_c, act_b, act_g, exp_code(i), e_b, e_g);
                end
            end
        end
    end

    task automatic drive(bit w, bit r, int a, int d);
        @(negedge clk); #1;
        bus_wr = w; bus_rd = r; bus_addr = 5'(a); bus_wdata = 16'(d);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) drive(0, 0, 0, 0);
    endtask

    // Explicit literal checks, taken after the settling negedge
    task automatic chk_code(int i, int exp, string req);
        int act;
        act = dac_code_o[i*DW +: DW];
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s ch%0d literal: actual %h expected %h", req, i, act, exp);
        end
    endtask

    task automatic chk_range(int eb, int eg, string req);
        n_checks++;
        if (bipolar_o != 4'(eb) || gain_o != 4'(eg)) begin
            n_fail++;
            $display("FAIL %s range: actual bip=%b gain=%b expected bip=%b gain=%b",
                     req, bipolar_o, gain_o, 4'(eb), 4'(eg));
        end
    endtask

    task automatic settle();
        @(negedge clk); #1;
        bus_wr = 0; bus_rd = 0;
        @(negedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst_n = 1;
        @(negedge clk); #1;
        cur_req = "R1";
        for (int i = 0; i < NCH; i++) chk_code(i, 'h800, "R1");
        chk_range(0, 0, "R1");

        // R9: enable, unbuffered
        cur_req = "R9";
        drive(1, 0, 1, 'h0002);
        settle();
        chk_code(0, 0, "R9");

        // R2 / R6: direct code writes, high bits dropped
        cur_req = "R6";
        drive(1, 0, 10, 'hFABC);
        settle();
        chk_code(0, 'hABC, "R6");
        cur_req = "R2";
        for (int i = 0; i < NCH; i++) drive(1, 0, 10 + i, 'h5000 + 'h111 * (i + 1));
        settle();
        for (int i = 0; i < NCH; i++) chk_code(i, 'h111 * (i + 1), "R2");

        // R3 / R7: direct range write, stray bits ignored
        cur_req = "R7";
        drive(1, 0, 9, 'hFA5F);
        settle();
        chk_range('b1010, 'b0101, "R3");

        // R4: buffered data, committed together
        cur_req = "R4";
        drive(1, 0, 1, 'h0003);
        for (int i = 0; i < NCH; i++) drive(1, 0, 10 + i, 'h700 + i);
        settle();
        chk_code(2, 'h333, "R4");
        drive(0, 1, 1, 0);
        settle();
        for (int i = 0; i < NCH; i++) chk_code(i, 'h700 + i, "R4");

        // R5: buffered range
        cur_req = "R5";
        drive(1, 0, 9, 'h0500);
        settle();
        chk_range('b1010, 'b0101, "R5");
        drive(0, 1, 9, 0);
        settle();
        chk_range('b0000, 'b1010, "R5");

        // R11: stray traffic changes nothing staged or live
        cur_req = "R11";
        drive(1, 0, 11, 'h0AAA);
        drive(0, 1, 5, 0);
        drive(0, 1, 10, 0);
        drive(1, 0, 15, 'h0FFF);
        drive(1, 0, 3, 'h0FFF);
        drive(0, 1, 0, 0);
        settle();
        chk_code(1, 'h701, "R11");
        drive(0, 1, 1, 0);
        settle();
        chk_code(1, 'hAAA, "R11");
        chk_code(0, 'h700, "R11");

        // R8: disabled parks midscale, staging still loads
        cur_req = "R8";
        drive(1, 0, 1, 'h0001);
        settle();
        for (int i = 0; i < NCH; i++) chk_code(i, 'h800, "R8");
        drive(1, 0, 13, 'h0123);
        drive(0, 1, 1, 0);
        settle();
        chk_code(3, 'h800, "R8");
        drive(1, 0, 1, 'h0003);
        settle();
        chk_code(3, 'h123, "R8");

        // R10: hold with idle bus
        cur_req = "R10";
        idle(10);
        chk_code(3, 'h123, "R10");

        // Mixed traffic against the model
        cur_req = "R4/R6 mixed";
        for (int k = 0; k < 400; k++) begin
            int a, d;
            a = $urandom_range(0, 15);
            d = $urandom;
            if ($urandom_range(0, 1) == 1) drive(1, 0, a, d);
            else                           drive(0, 1, a, d);
        end
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule